// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

This block holds the power-management event registers of a PCI power-management function and drives its level-sensitive system control interrupt (SCI). Four event sources set bits in a 16-bit event status register: a timer-overflow event, a power-button event, a global-lock event and an RTC-alarm event. A matching 16-bit enable register gates each of these into the SCI. A plain 16-bit control word sits beside them. Status bits are cleared by writing ones to them.

Software reaches the registers through a relocatable 64-byte I/O window. The window base comes from a 32-bit configuration dword with its low six bits dropped. A separate configuration byte carries the enable bit. When the window is disabled, or an access falls outside it, nothing in the block changes and reads return zero. A free-running timer advances on a tick input. Each change of its most significant bit sets the timer status bit.

A three-state machine follows the timer-overflow arming. `ARM_OFF` holds while the timer enable bit is clear. `ARM_ON` holds while the timer is enabled and its status is clear, and it drives `tmr_armed`. `ARM_HIT` holds while the timer is enabled and its status is set. The transitions are named by cause. `to_on` is taken when the enable is set, or when the status is cleared under enable. `to_hit` is taken when a timer flip arrives under enable. `to_off` is taken from any state when the enable is cleared. Every state moves on the register values being written in the same cycle, so the state always matches the registers.

Top module: `pm_acpi_evt`

## Requirements
- R1: `io_hit` is high exactly when `cfg_pm_ctl[0]` is 1 and `io_addr[15:6]` equals `cfg_pm_base[15:6]`. Bits 5:0 and 31:16 of the base are ignored.
- R2: After reset, the status, enable and control registers and the timer all read zero. `pci_command` is 16'h0000 and `pci_status` is 16'h0280, which is fast back-to-back (bit 7) plus medium DEVSEL (bits 10:9 = 01).
- R3: The status register sits at window offset 0. Only bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) exist. Other bits read 0. Writing 1 to an implemented bit clears it, and writing 0 leaves it unchanged.
- R4: The enable register at offset 2 and the control register at offset 4 each store and read back all 16 bits written.
- R5: A high `evt_pwrbtn`, `evt_glock` or `evt_rtc` on a clock edge sets status bit 8, 5 or 10 respectively. A set and a write-one-to-clear of the same bit on the same edge leave the bit set.
- R6: `sci` is high exactly when any of status bits 0, 5, 8 or 10 is set together with the enable bit at the same position.
- R7: The timer advances by one on each clock edge with `tmr_tick` high. Its low 16 bits read at offset 8 and its upper bits read at offset 10. Writes to either offset are ignored.
- R8: Every change of the timer's most significant bit, whether rising or falling, sets status bit 0 on the same edge.
- R9: `tmr_armed` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R10: A write that misses the window leaves every register unchanged. While `io_hit` is low, `io_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pm_base | input | 32 | Configuration dword giving the window base |
| cfg_pm_ctl | input | 8 | Configuration byte; bit 0 enables the window |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe for one cycle |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data for `io_addr`; zero on a miss |
| io_hit | output | 1 | Address falls inside the enabled window |
| tmr_tick | input | 1 | Timer clock enable |
| evt_pwrbtn | input | 1 | Power-button event |
| evt_glock | input | 1 | Global-lock event |
| evt_rtc | input | 1 | RTC-alarm event |
| sci | output | 1 | Active-high SCI level |
| tmr_armed | output | 1 | Timer-overflow event is armed |
| pci_command | output | 16 | Reset value of the PCI command word |
| pci_status | output | 16 | Reset value of the PCI status word |

## Verification
The bench probes the window edges: the last byte inside, the first byte after, the word just below, and a base whose low and high bits are junk. A decoder that compared too many bits, or that ignored the enable bit, would hit or miss in the wrong place. It writes zeros and ones to the status register and holds an event high during a clear of the same bit. A design that did plain stores, or that let the clear win, would lose pending events. The timer is run across both the rising and falling flips of its top bit, so a design that caught only overflow would miss the second status set. The bench also checks the arming output through clear and re-arm.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int BLK_BITS = 6;

    localparam logic [5:0] OFF_STS = 6'h00;
    localparam logic [5:0] OFF_EN  = 6'h02;
    localparam logic [5:0] OFF_CTL = 6'h04;
    localparam logic [5:0] OFF_TLO = 6'h08;
    localparam logic [5:0] OFF_THI = 6'h0A;

    localparam int BIT_TMR = 0;
    localparam int BIT_GLK = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_RTC = 10;

    localparam logic [15:0] EVT_MASK = (16'h1 << BIT_TMR) | (16'h1 << BIT_GLK) |
                                       (16'h1 << BIT_PWR) | (16'h1 << BIT_RTC);

    localparam logic [15:0] PCI_CMD_RST = 16'h0000;
    localparam logic [15:0] PCI_STS_RST = 16'h0280;

    typedef enum logic [1:0] {
        ARM_OFF = 2'd0,
        ARM_ON  = 2'd1,
        ARM_HIT = 2'd2
    } arm_state_e;

endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
    parameter int AW  = 16,
    parameter int BLK = 6
) (
    input  logic [31:0]    base,
    input  logic [7:0]     ctl,
    input  logic [AW-1:0]  addr,
    output logic           hit,
    output logic [BLK-1:0] off
);
    logic unused_cfg;

    assign hit = ctl[0] && (addr[AW-1:BLK] == base[AW-1:BLK]);
    assign off = {addr[BLK-1:1], 1'b0};
    assign unused_cfg = ^{base[31:AW], base[BLK-1:0], ctl[7:1], addr[0]};

    // R1
    always_comb begin
        if (!ctl[0]) begin
            win_off_chk: assert (!hit);
        end
    end
endmodule

// File: rtl/pm_tmr.sv
module pm_tmr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic         flip
);
    assign flip = tick && (&cnt_q[W-2:0]);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // R7
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs import pm_evt_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [5:0]  off,
    input  logic [15:0] wdata,
    input  logic        tmr_flip,
    input  logic        evt_pwrbtn,
    input  logic        evt_glock,
    input  logic        evt_rtc,
    output logic [15:0] sts_q,
    output logic [15:0] en_q,
    output logic [15:0] ctl_q,
    output logic        armed
);
    logic [15:0] sts_d, en_d, ctl_d;
    arm_state_e  state_q, state_d;

    always_comb begin
        sts_d = sts_q;
        if (wr && off == OFF_STS) sts_d = sts_q & ~(wdata & EVT_MASK);
        sts_d[BIT_TMR] = sts_d[BIT_TMR] | tmr_flip;
        sts_d[BIT_GLK] = sts_d[BIT_GLK] | evt_glock;
        sts_d[BIT_PWR] = sts_d[BIT_PWR] | evt_pwrbtn;
        sts_d[BIT_RTC] = sts_d[BIT_RTC] | evt_rtc;
        en_d  = (wr && off == OFF_EN)  ? wdata : en_q;
        ctl_d = (wr && off == OFF_CTL) ? wdata : ctl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
            ctl_q <= ctl_d;
        end
    end

    // arming state machine: transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_OFF: if (en_d[BIT_TMR])
                         state_d = sts_d[BIT_TMR] ? ARM_HIT : ARM_ON;
            ARM_ON:  if (!en_d[BIT_TMR])     state_d = ARM_OFF;
                     else if (sts_d[BIT_TMR]) state_d = ARM_HIT;
            ARM_HIT: if (!en_d[BIT_TMR])      state_d = ARM_OFF;
                     else if (!sts_d[BIT_TMR]) state_d = ARM_ON;
            default: state_d = ARM_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_OFF;
        else        state_q <= state_d;
    end

    // arming state machine: outputs
    always_comb begin
        unique case (state_q)
            ARM_ON:  armed = 1'b1;
            default: armed = 1'b0;
        endcase
    end

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_STS && wdata[BIT_GLK] && !evt_glock) |=> !sts_q[BIT_GLK]);
    // R8
    tmr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_flip |=> sts_q[BIT_TMR]);
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rtc |=> sts_q[BIT_RTC]);
    // R9
    armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (en_q[BIT_TMR] && !sts_q[BIT_TMR]));
endmodule

// File: rtl/pm_acpi_evt.sv
module pm_acpi_evt import pm_evt_pkg::*; #(
    parameter int TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_pm_base,
    input  logic [7:0]  cfg_pm_ctl,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic [15:0] io_wdata,
    output logic [15:0] io_rdata,
    output logic        io_hit,
    input  logic        tmr_tick,
    input  logic        evt_pwrbtn,
    input  logic        evt_glock,
    input  logic        evt_rtc,
    output logic        sci,
    output logic        tmr_armed,
    output logic [15:0] pci_command,
    output logic [15:0] pci_status
);
    logic [BLK_BITS-1:0] off;
    logic [TMR_W-1:0]    tmr_cnt;
    logic [31:0]         tmr_ext;
    logic                tmr_flip;
    logic [15:0]         sts_q, en_q, ctl_q;

    pm_win_decode #(.AW(16), .BLK(BLK_BITS)) u_dec (
        .base(cfg_pm_base), .ctl(cfg_pm_ctl), .addr(io_addr),
        .hit(io_hit), .off(off)
    );

    pm_tmr #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tmr_tick),
        .cnt_q(tmr_cnt), .flip(tmr_flip)
    );

    pm_evt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(io_wr && io_hit), .off(off),
        .wdata(io_wdata), .tmr_flip(tmr_flip), .evt_pwrbtn(evt_pwrbtn),
        .evt_glock(evt_glock), .evt_rtc(evt_rtc),
        .sts_q(sts_q), .en_q(en_q), .ctl_q(ctl_q), .armed(tmr_armed)
    );

    assign tmr_ext     = 32'(tmr_cnt);
    assign sci         = |(sts_q & en_q & EVT_MASK);
    assign pci_command = PCI_CMD_RST;
    assign pci_status  = PCI_STS_RST;

    always_comb begin
        io_rdata = '0;
        if (io_hit) begin
            unique case (off)
                OFF_STS: io_rdata = sts_q & EVT_MASK;
                OFF_EN:  io_rdata = en_q;
                OFF_CTL: io_rdata = ctl_q;
                OFF_TLO: io_rdata = tmr_ext[15:0];
                OFF_THI: io_rdata = tmr_ext[31:16];
                default: io_rdata = '0;
            endcase
        end
    end

    // R10
    miss_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_hit) |=> ($stable(en_q) && $stable(ctl_q)));
endmodule

// File: tb/tb_pm_acpi_evt.sv
module tb_pm_acpi_evt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_pm_base = 32'h0000_4000;
    logic [7:0]  cfg_pm_ctl = 8'h01;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic [15:0] io_wdata = 16'h0;
    logic [15:0] io_rdata;
    logic        io_hit;
    logic        tmr_tick = 1'b0;
    logic        evt_pwrbtn = 1'b0, evt_glock = 1'b0, evt_rtc = 1'b0;
    logic        sci, tmr_armed;
    logic [15:0] pci_command, pci_status;
    int total = 0, bad = 0;
    bit finished = 0;

    localparam logic [15:0] B = 16'h4000;

    pm_acpi_evt #(.TMR_W(8)) dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        io_addr = a; #1; v = io_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tmr_tick = 1'b1;
        repeat (n) @(negedge clk);
        tmr_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(B + 0, v);  chk("R2 sts", v, 0);
        rd(B + 2, v);  chk("R2 en", v, 0);
        rd(B + 4, v);  chk("R2 ctl", v, 0);
        rd(B + 8, v);  chk("R2 tmr", v, 0);
        chk("R2 cmd", pci_command, 16'h0000);
        chk("R2 stat", pci_status, 16'h0280);
        chk("R2 sci", sci, 0);
    endtask

    task automatic t_decode();
        cfg_pm_base = 32'hABCD_E435; #1;
        io_addr = 16'hE400; #1; chk("R1 base", io_hit, 1);
        io_addr = 16'hE43F; #1; chk("R1 top", io_hit, 1);
        io_addr = 16'hE440; #1; chk("R1 after", io_hit, 0);
        io_addr = 16'hE3FE; #1; chk("R1 below", io_hit, 0);
        cfg_pm_ctl = 8'hFE; io_addr = 16'hE400; #1; chk("R1 off", io_hit, 0);
        cfg_pm_ctl = 8'h01; cfg_pm_base = 32'h0000_4000; #1;
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(B + 2, 16'hA5C3); rd(B + 2, v); chk("R4 en", v, 16'hA5C3);
        wr(B + 4, 16'h5A3C); rd(B + 4, v); chk("R4 ctl", v, 16'h5A3C);
        wr(B + 8, 16'h00FF); rd(B + 8, v); chk("R7 ro", v, 0);
        wr(B + 2, 16'h0000);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        @(negedge clk); evt_pwrbtn = 1; evt_glock = 1; evt_rtc = 1;
        @(negedge clk); evt_pwrbtn = 0; evt_glock = 0; evt_rtc = 0;
        rd(B, v); chk("R5 set", v, 16'h0520);
        wr(B, 16'h0000); rd(B, v); chk("R3 w0", v, 16'h0520);
        wr(B, 16'hFADF); rd(B, v); chk("R3 partial", v, 16'h0520);
        wr(B, 16'h0100); rd(B, v); chk("R3 clr8", v, 16'h0420);
        @(negedge clk); evt_rtc = 1; io_addr = B; io_wdata = 16'h0400; io_wr = 1;
        @(negedge clk); evt_rtc = 0; io_wr = 0;
        rd(B, v); chk("R5 setwins", v, 16'h0420);
        wr(B, 16'hFFFF); rd(B, v); chk("R3 all", v, 0);
    endtask

    task automatic t_sci();
        @(negedge clk); evt_glock = 1; @(negedge clk); evt_glock = 0;
        chk("R6 no en", sci, 0);
        wr(B + 2, 16'h0020); chk("R6 en", sci, 1);
        wr(B + 2, 16'hFADF); chk("R6 other", sci, 0);
        wr(B + 2, 16'h0020); wr(B, 16'h0020); chk("R6 clr", sci, 0);
        wr(B + 2, 16'h0000);
    endtask

    task automatic t_miss();
        logic [15:0] v;
        wr(B + 4, 16'h1234);
        wr(16'h4040, 16'hFFFF);
        wr(16'h5004, 16'hFFFF);
        rd(B + 4, v); chk("R10 keep", v, 16'h1234);
        rd(16'h4044, v); chk("R10 rd0", v, 0);
        cfg_pm_ctl = 8'h00; wr(B + 4, 16'h9999);
        rd(B + 4, v); chk("R10 dis rd0", v, 0);
        cfg_pm_ctl = 8'h01; #1;
        rd(B + 4, v); chk("R10 dis keep", v, 16'h1234);
    endtask

    task automatic t_timer();
        logic [15:0] v;
        wr(B + 2, 16'h0001); chk("R9 armed", tmr_armed, 1);
        ticks(127);
        rd(B, v); chk("R8 pre", v, 0);
        ticks(1);
        rd(B, v); chk("R8 rise", v, 16'h0001);
        rd(B + 8, v); chk("R7 lo", v, 16'h0080);
        rd(B + 10, v); chk("R7 hi", v, 0);
        chk("R6 tmr", sci, 1);
        chk("R9 hit", tmr_armed, 0);
        wr(B, 16'h0001); chk("R9 rearm", tmr_armed, 1);
        ticks(127); rd(B, v); chk("R8 pre2", v, 0);
        ticks(1); rd(B, v); chk("R8 fall", v, 16'h0001);
        rd(B + 8, v); chk("R7 wrap", v, 0);
        wr(B + 2, 16'h0000); chk("R9 off", tmr_armed, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_regs();
        t_w1c();
        t_sci();
        t_miss();
        t_timer();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule